// File: doc/BRIEF.md
# Key and Coded Trigger Controller

This block turns the trigger pins of a voice-playback device into start and stop commands for the playback sequencer. Each raw input is filtered against bounce. The filter counts a sample-rate tick enable, so the hold time scales with the sample rate. In key mode, each of the first keys selects one group directly. A separate single-button input steps a pointer through the groups that lie above the direct keys. In coded mode, the low keys carry a binary group number. A press of the single-button input acts as the strobe that latches that number.

Each group carries its own three option bits, loaded through a small configuration write port. The first bit picks edge or level triggering. The second picks whether the group is holdable, meaning it plays only while its trigger is held. The third picks whether a new request can cut into the group while it plays. An interrupt input stops playback at once. The sequencer reports the end of a group back through `end_i`.

Top module: `trig_ctrl`

## Requirements
- R1: After reset, `start_o` and `stop_o` are low and `grp_o` is 0.
- R2: In key mode, a filtered rising edge on key i starts the group with index i. `grp_o` carries the group number minus one. When several keys rise together, the lowest index wins.
- R3: An input counts as changed only after it has held its new level for DEBOUNCE_TICKS consecutive ticks. A press shorter than that starts nothing.
- R4: In key mode, each filtered press on `seq_i` starts the group at the sequential pointer. The pointer begins at index NUM_KEYS. It advances by one per press and returns to NUM_KEYS after the press that used index `last_grp_i`.
- R5: In coded mode, a filtered press on `seq_i` starts the group whose index equals the code on `key_i[CODE_W-1:0]`, with `key_i[CODE_W-1]` as the MSB. Presses on keys alone start nothing, and keys at or above CODE_W do not affect the code.
- R6: The two highest codes (all ones, and all ones except the LSB) never start playback. Neither does any code at or above NUM_GROUPS.
- R7: A high `irq_stop_i` during playback gives a `stop_o` pulse on the next cycle. No `start_o` follows any cycle in which `irq_stop_i` is high.
- R8: For a holdable group, releasing the input that started it issues `stop_o` and ends playback.
- R9: When `end_i` arrives, a level-triggered group starts again if the input that started it is still held. An edge-triggered group does not start again and waits for a new press.
- R10: During playback of a retriggerable group, a new request starts its group at once. During playback of a non-retriggerable group, new requests are ignored.
- R11: When `cfg_we_i` is high, `cfg_opt_i` is stored for the group at `cfg_addr_i`. Bit 0 selects edge (1) or level (0). Bit 1 selects holdable. Bit 2 selects retriggerable. The reset value is 0 for every group.
- R12: `start_o` and `stop_o` are one-cycle pulses and are never high together. `grp_o` changes only together with `start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Sample-rate tick enable that times the debounce |
| cpu_mode_i | input | 1 | 1 selects coded mode, 0 selects key mode |
| key_i | input | NUM_KEYS | Raw trigger keys, active high |
| seq_i | input | 1 | Raw sequential step input, which is also the strobe in coded mode |
| irq_stop_i | input | 1 | Immediate stop request, not filtered |
| last_grp_i | input | CODE_W | Index of the last group reached by the sequential pointer |
| cfg_we_i | input | 1 | Option write enable |
| cfg_addr_i | input | CODE_W | Group index to write |
| cfg_opt_i | input | 3 | Option bits {retrig, hold, edge} |
| end_i | input | 1 | End-of-group pulse from the sequencer |
| start_o | output | 1 | Start pulse for the group on `grp_o` |
| stop_o | output | 1 | Stop pulse to the sequencer |
| grp_o | output | CODE_W | Index of the group most recently started |

## Verification
The bench uses the default eight keys, a 5-bit code and thirty groups. It shortens the debounce to 4 ticks and raises `tick_i` only every third clock. This makes a filter window take about a dozen cycles. A 4-cycle glitch and a full press therefore both fit in a short run, and the tick gating is exercised as well. Setting `last_grp_i` to 11 keeps the sequential range to four groups, so a single test steps the pointer through a full wrap. Coded mode is driven with a valid code, with the highest valid code, and with both reserved codes.

// File: rtl/trig_pkg.sv
// Shared types of the trigger controller: the per-group option word.
package trig_pkg;
    // Per-group options; packed order gives bit2 retrig, bit1 hold, bit0 edge.
    typedef struct packed {
        logic retrig;
        logic hold;
        logic edge_mode;
    } trig_opt_t;

    localparam int OPT_W = $bits(trig_opt_t);
endpackage

// File: rtl/trig_debounce.sv
// Input filter: the stable level follows the raw input only after the raw
// input has differed from it for DEB_TICKS consecutive ticks.
// Assumes raw_i is already synchronous to clk. rise_o pulses in the same
// cycle that the stable level goes high.
module trig_debounce #(
    parameter int DEB_TICKS = 132
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic lvl_o,
    output logic rise_o
);
    localparam int CNT_W = $clog2(DEB_TICKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             lvl_q;
    logic             rise_q;

    // Count ticks of disagreement and take the new level once the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (raw_i == lvl_q) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == CNT_W'(DEB_TICKS - 1)) begin
                    cnt_q  <= '0;
                    lvl_q  <= raw_i;
                    rise_q <= raw_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = rise_q;
endmodule

// File: rtl/trig_opt_regs.sv
// Option register file: one option word per group, written at configuration
// time. It has one combinational read port. Addresses beyond NUM_GROUPS
// read zero and are not written.
module trig_opt_regs
    import trig_pkg::*;
#(
    parameter int NUM_GROUPS = 30,
    parameter int CODE_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CODE_W-1:0] waddr_i,
    input  trig_opt_t         wdata_i,
    input  logic [CODE_W-1:0] raddr_i,
    output trig_opt_t         rdata_o
);
    trig_opt_t mem_q [NUM_GROUPS];

    // Clear all options on reset; store a word on a valid write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GROUPS; g++) mem_q[g] <= '0;
        end else if (we_i && (int'(waddr_i) < NUM_GROUPS)) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Guarded read of the addressed group.
    always_comb begin
        rdata_o = '0;
        if (int'(raddr_i) < NUM_GROUPS) rdata_o = mem_q[raddr_i];
    end
endmodule

// File: rtl/trig_select.sv
// Request encoder: turns filtered edges into one request per cycle.
// Key mode: the lowest rising key wins, otherwise a step press takes the
// sequential pointer. Coded mode: a step press latches the low key levels
// as a group code; reserved and out-of-range codes make no request.
module trig_select #(
    parameter int NUM_KEYS   = 8,
    parameter int NUM_GROUPS = 30,
    parameter int CODE_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_mode_i,
    input  logic [NUM_KEYS-1:0]         key_rise_i,
    input  logic [CODE_W-1:0]           code_i,
    input  logic                        seq_rise_i,
    input  logic [CODE_W-1:0]           last_grp_i,
    output logic                        req_v_o,
    output logic [CODE_W-1:0]           req_grp_o,
    output logic                        req_seq_o,
    output logic [$clog2(NUM_KEYS)-1:0] req_idx_o
);
    localparam int IDX_W    = $clog2(NUM_KEYS);
    localparam int MAX_CODE = (1 << CODE_W) - 2;
    localparam int LIMIT    = (NUM_GROUPS < MAX_CODE) ? NUM_GROUPS : MAX_CODE;
    localparam logic [CODE_W-1:0] FIRST_SEQ = CODE_W'(NUM_KEYS);

    logic [CODE_W-1:0] ptr_q;
    logic              wrap;

    assign wrap = (ptr_q >= last_grp_i) || (int'(ptr_q) >= LIMIT - 1);

    // Step the sequential pointer on each step press in key mode that is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= FIRST_SEQ;
        end else if (!cpu_mode_i && seq_rise_i && (key_rise_i == '0)) begin
            ptr_q <= wrap ? FIRST_SEQ : ptr_q + 1'b1;
        end
    end

    // Pick the winning request of this cycle.
    always_comb begin
        req_v_o   = 1'b0;
        req_grp_o = '0;
        req_seq_o = 1'b0;
        req_idx_o = '0;
        if (cpu_mode_i) begin
            if (seq_rise_i && (int'(code_i) < LIMIT)) begin
                req_v_o   = 1'b1;
                req_grp_o = code_i;
                req_seq_o = 1'b1;
            end
        end else begin
            if (seq_rise_i) begin
                req_v_o   = 1'b1;
                req_grp_o = ptr_q;
                req_seq_o = 1'b1;
            end
            for (int i = NUM_KEYS - 1; i >= 0; i--) begin
                if (key_rise_i[i]) begin
                    req_v_o   = 1'b1;
                    req_grp_o = CODE_W'(i);
                    req_seq_o = 1'b0;
                    req_idx_o = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/trig_ctrl.sv
// Trigger controller top: filters the trigger inputs and holds the play state.
// It issues start/stop pulses by the current group's options.
// Assumes all inputs are synchronous to clk and that end_i is a one-cycle
// pulse from the sequencer. Priority: interrupt, hold release, retrigger
// request, end of group, new request while idle.
module trig_ctrl
    import trig_pkg::*;
#(
    parameter int NUM_KEYS   = 8,
    parameter int NUM_GROUPS = 30,
    parameter int CODE_W     = 5,
    parameter int DEB_TICKS  = 132
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                cpu_mode_i,
    input  logic [NUM_KEYS-1:0] key_i,
    input  logic                seq_i,
    input  logic                irq_stop_i,
    input  logic [CODE_W-1:0]   last_grp_i,
    input  logic                cfg_we_i,
    input  logic [CODE_W-1:0]   cfg_addr_i,
    input  logic [OPT_W-1:0]    cfg_opt_i,
    input  logic                end_i,
    output logic                start_o,
    output logic                stop_o,
    output logic [CODE_W-1:0]   grp_o
);
    localparam int IDX_W = $clog2(NUM_KEYS);

    logic [NUM_KEYS-1:0] key_lvl, key_rise;
    logic                seq_lvl, seq_rise;
    logic                req_v, req_seq;
    logic [CODE_W-1:0]   req_grp;
    logic [IDX_W-1:0]    req_idx;
    trig_opt_t           cur_opt;

    logic                play_q, play_n;
    logic                start_q, start_n, stop_q, stop_n;
    logic [CODE_W-1:0]   grp_q, grp_n;
    logic                src_seq_q, src_seq_n;
    logic [IDX_W-1:0]    src_idx_q, src_idx_n;
    logic                src_lvl;

    // One filter per key.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        trig_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
            .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
            .raw_i(key_i[k]), .lvl_o(key_lvl[k]), .rise_o(key_rise[k])
        );
    end

    trig_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .raw_i(seq_i), .lvl_o(seq_lvl), .rise_o(seq_rise)
    );

    trig_select #(.NUM_KEYS(NUM_KEYS), .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .cpu_mode_i(cpu_mode_i),
        .key_rise_i(key_rise), .code_i(key_lvl[CODE_W-1:0]),
        .seq_rise_i(seq_rise), .last_grp_i(last_grp_i),
        .req_v_o(req_v), .req_grp_o(req_grp), .req_seq_o(req_seq), .req_idx_o(req_idx)
    );

    trig_opt_regs #(.NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) u_opt (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .waddr_i(cfg_addr_i),
        .wdata_i(trig_opt_t'(cfg_opt_i)), .raddr_i(grp_q), .rdata_o(cur_opt)
    );

    // Level of the input that started the current group.
    assign src_lvl = src_seq_q ? seq_lvl : key_lvl[src_idx_q];

    // Next play state and command pulses.
    always_comb begin
        play_n    = play_q;
        start_n   = 1'b0;
        stop_n    = 1'b0;
        grp_n     = grp_q;
        src_seq_n = src_seq_q;
        src_idx_n = src_idx_q;
        if (irq_stop_i) begin
            stop_n = play_q;
            play_n = 1'b0;
        end else if (play_q && cur_opt.hold && !src_lvl) begin
            stop_n = 1'b1;
            play_n = 1'b0;
        end else if (req_v && (!play_q || cur_opt.retrig)) begin
            start_n   = 1'b1;
            play_n    = 1'b1;
            grp_n     = req_grp;
            src_seq_n = req_seq;
            src_idx_n = req_idx;
        end else if (play_q && end_i) begin
            if (!cur_opt.edge_mode && src_lvl) start_n = 1'b1;
            else                               play_n  = 1'b0;
        end
    end

    // Register state and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_q    <= 1'b0;
            start_q   <= 1'b0;
            stop_q    <= 1'b0;
            grp_q     <= '0;
            src_seq_q <= 1'b0;
            src_idx_q <= '0;
        end else begin
            play_q    <= play_n;
            start_q   <= start_n;
            stop_q    <= stop_n;
            grp_q     <= grp_n;
            src_seq_q <= src_seq_n;
            src_idx_q <= src_idx_n;
        end
    end

    assign start_o = start_q;
    assign stop_o  = stop_q;
    assign grp_o   = grp_q;
endmodule

// File: rtl/trig_ctrl_chk.sv
// Property checker for trig_ctrl, attached by bind. It watches the ports and
// the play state.
module trig_ctrl_chk #(
    parameter int NUM_GROUPS = 30,
    parameter int CODE_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_stop_i,
    input logic              start_o,
    input logic              stop_o,
    input logic [CODE_W-1:0] grp_o,
    input logic              play_q
);
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    a_r12_grp_moves_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_o != $past(grp_o)) |-> start_o);

    a_r7_irq_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stop_i |=> !start_o);

    a_r7_irq_stops_play: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stop_i && play_q) |=> (stop_o && !play_q));

    a_r6_grp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (int'(grp_o) < NUM_GROUPS));

    a_r8_stop_ends_play: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !play_q);
endmodule

bind trig_ctrl trig_ctrl_chk #(.NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_stop_i(irq_stop_i),
    .start_o(start_o), .stop_o(stop_o), .grp_o(grp_o), .play_q(play_q)
);

// File: tb/sim_trig_ctrl.sv
`timescale 1ns/1ps
// Directed bench for trig_ctrl: one task per scenario.
module sim_trig_ctrl;
    localparam int NK = 8;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cpu_mode = 1'b0;
    logic [NK-1:0] keys = '0;
    logic          seq = 1'b0;
    logic          irq = 1'b0;
    logic [CW-1:0] last_grp = 5'd11;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_addr = '0;
    logic [2:0]    cfg_opt = '0;
    logic          end_p = 1'b0;
    logic          start_o, stop_o;
    logic [CW-1:0] grp_o;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    trig_ctrl #(.NUM_KEYS(NK), .NUM_GROUPS(30), .CODE_W(CW), .DEB_TICKS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cpu_mode_i(cpu_mode),
        .key_i(keys), .seq_i(seq), .irq_stop_i(irq), .last_grp_i(last_grp),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_opt_i(cfg_opt),
        .end_i(end_p), .start_o(start_o), .stop_o(stop_o), .grp_o(grp_o)
    );

    always #2 clk = ~clk;

    // Tick on every third cycle, driven away from the active edge.
    always @(negedge clk) begin
        tcnt <= (tcnt == 2) ? 0 : tcnt + 1;
        tick <= (tcnt == 2);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Look for a start pulse within n cycles; checks the current cycle first.
    task automatic wait_start(input int n, output bit seen, output int g);
        seen = 0;
        g = -1;
        for (int i = 0; i < n; i++) begin
            if (start_o) begin
                seen = 1;
                g = int'(grp_o);
                chk(!stop_o, "R12 start/stop overlap", 1, 0);
                @(negedge clk);
                chk(!start_o, "R12 start is one cycle", int'(start_o), 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_stop(input int n, output bit seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            if (stop_o) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse_end;
        @(negedge clk) end_p = 1'b1;
        @(negedge clk) end_p = 1'b0;
    endtask

    task automatic cfg(input int g, input logic [2:0] o);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CW'(g); cfg_opt = o;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_start(input string req, input int exp_g);
        bit s; int g;
        wait_start(40, s, g);
        chk(s, req, int'(s), 1);
        chk(g == exp_g, req, g, exp_g);
    endtask

    task automatic expect_none(input string req, input int n);
        bit s; int g;
        wait_start(n, s, g);
        chk(!s, req, int'(s), 0);
    endtask

    task automatic t_reset;
        chk(!start_o, "R1 start after reset", int'(start_o), 0);
        chk(!stop_o,  "R1 stop after reset",  int'(stop_o), 0);
        chk(grp_o == 0, "R1 grp after reset", int'(grp_o), 0);
    endtask

    task automatic t_glitch;
        @(negedge clk) keys[0] = 1'b1;
        idle(4);
        keys[0] = 1'b0;
        expect_none("R3 short press ignored", 40);
    endtask

    task automatic t_key_level;
        @(negedge clk) keys[2] = 1'b1;
        expect_start("R2 key 3 starts index 2", 2);
        pulse_end;
        expect_start("R9 level restart while held", 2);
        keys[2] = 1'b0;
        idle(30);
        pulse_end;
        expect_none("R9 no restart after release", 20);
    endtask

    task automatic t_key_priority;
        @(negedge clk) keys = 8'b0010_1000;
        expect_start("R2 lowest key wins", 3);
        keys = '0;
        idle(30);
        pulse_end;
        idle(5);
    endtask

    task automatic t_sequential;
        int exp_g [5] = '{8, 9, 10, 11, 8};
        foreach (exp_g[i]) begin
            @(negedge clk) seq = 1'b1;
            expect_start("R4 sequential pointer", exp_g[i]);
            seq = 1'b0;
            idle(30);
            pulse_end;
            idle(5);
        end
    endtask

    task automatic t_edge;
        cfg(0, 3'b001);
        @(negedge clk) keys[0] = 1'b1;
        expect_start("R11 edge group starts", 0);
        pulse_end;
        expect_none("R9 edge group no restart", 20);
        keys[0] = 1'b0;
        idle(30);
    endtask

    task automatic t_hold;
        bit s;
        cfg(1, 3'b010);
        @(negedge clk) keys[1] = 1'b1;
        expect_start("R8 holdable group starts", 1);
        idle(10);
        keys[1] = 1'b0;
        wait_stop(40, s);
        chk(s, "R8 release gives stop", int'(s), 1);
        idle(5);
    endtask

    task automatic t_retrig;
        cfg(4, 3'b100);
        @(negedge clk) keys[4] = 1'b1;
        expect_start("R10 retrig group starts", 4);
        keys[6] = 1'b1;
        expect_start("R10 retrig cut in", 6);
        keys[7] = 1'b1;
        expect_none("R10 non-retrig ignores key", 40);
        keys = '0;
        idle(30);
        pulse_end;
        expect_none("R10 idle after end", 10);
    endtask

    task automatic t_irq;
        bit s;
        @(negedge clk) keys[3] = 1'b1;
        expect_start("R7 group starts before stop", 3);
        @(negedge clk) irq = 1'b1;
        @(negedge clk);
        chk(stop_o, "R7 stop next cycle", int'(stop_o), 1);
        keys[3] = 1'b0;
        keys[5] = 1'b1;
        expect_none("R7 no start while stop held", 40);
        irq = 1'b0;
        expect_none("R7 press during stop lost", 20);
        keys = '0;
        wait_stop(30, s);
        chk(!s, "R7 no stray stop", int'(s), 0);
    endtask

    task automatic cpu_code(input logic [NK-1:0] k, input bit expect_play, input int exp_g,
                            input string req);
        @(negedge clk) keys = k;
        expect_none("R5 keys alone start nothing", 30);
        seq = 1'b1;
        if (expect_play) expect_start(req, exp_g);
        else             expect_none(req, 40);
        seq = 1'b0;
        idle(30);
        if (expect_play) pulse_end;
        keys = '0;
        idle(30);
    endtask

    task automatic t_cpu;
        cpu_mode = 1'b1;
        cpu_code(8'b1000_1010, 1, 10, "R5 code 01010 with high key 8");
        cpu_code(8'b0001_1101, 1, 29, "R5 code 11101");
        cpu_code(8'b0001_1110, 0, 0,  "R6 reserved code 11110");
        cpu_code(8'b0001_1111, 0, 0,  "R6 reserved code 11111");
        cpu_mode = 1'b0;
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_glitch;
        t_key_level;
        t_key_priority;
        t_sequential;
        t_edge;
        t_hold;
        t_retrig;
        t_irq;
        t_cpu;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule